// File: doc/BRIEF.md
# Guarded Floating-Point Sign Unit

This execution unit reads one 32-bit operand as an IEEE single-precision number and produces a 32-bit integer that gives the operand's sign. A positive value yields 1, a negative value yields all ones (-1), and zero yields 0. Subnormal operands are flushed to zero. Not-a-number operands give 0. Each of these two special cases also raises a sticky exception flag. Every operation carries the least significant bit of its guard register. When that bit is clear, the operation leaves both the destination and the flags untouched.

The unit is a three-stage pipeline and accepts a new operation every cycle. The destination index travels alongside the data. The result appears on a writeback port, and the status flags update on the same clock edge. The flag register also merges updates that other floating-point units deliver in the same cycle. Software can overwrite it through an explicit write port, and a read port shows its current contents.

Top module: `fsx_sign_unit`

## Requirements
- R1: An operand whose bits 30..0 are all zero (positive or negative zero) writes result 0 and raises no flag.
- R2: A normal operand or an infinity writes 0x00000001 when bit 31 is 0 and 0xFFFFFFFF when bit 31 is 1. This includes 0x80800000 and 0xFF800000.
- R3: A subnormal operand (exponent field 0, fraction non-zero) writes 0 and sets the flush flag, which is status bit 1.
- R4: A NaN operand (exponent field 0xFF, fraction non-zero), whether quiet or signaling, writes 0 and sets the invalid flag, which is status bit 0.
- R5: An operation presented with issue_valid and a guard of 1 appears on wb_valid, with its wb_dest and wb_data, exactly three rising edges later. Its flag bits reach stat_rd_data on that same edge.
- R6: With a guard of 0, the operation produces no wb_valid pulse and changes no status bit.
- R7: A status bit, once set, stays set until stat_wr_en is asserted.
- R8: The external update vector ext_flags holds one FLAG_W-bit slice per other unit, with slice i at bits [i*FLAG_W +: FLAG_W]. Every bit set in any slice is ORed into the status register on the next edge.
- R9: When stat_wr_en is high, the register first loads stat_wr_data and then ORs in the same cycle's own and external updates.
- R10: After reset, the status register reads 0 and wb_valid is low.
- R11: Operations issued on consecutive cycles each retire, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An operation is presented this cycle |
| issue_operand | input | 32 | Single-precision operand bits |
| issue_guard | input | 1 | Least significant bit of the guard register |
| issue_dest | input | DEST_W | Destination register index |
| ext_flags | input | NUM_EXT*FLAG_W | Simultaneous flag updates from other units |
| stat_wr_en | input | 1 | Explicit status-register write |
| stat_wr_data | input | FLAG_W | Value loaded by the explicit write |
| wb_valid | output | 1 | Destination write strobe |
| wb_dest | output | DEST_W | Destination register index of the write |
| wb_data | output | 32 | Integer sign result |
| stat_rd_data | output | FLAG_W | Current sticky status flags |

## Verification
The assertions assume that reset is held for at least one edge and that every input holds a known value from time zero. This matters because the sticky, external-merge and write-base properties all look one cycle back at the status register and the input vectors. The bench therefore drives every input to zero before the first edge. It changes inputs only on falling edges, so each rising edge samples settled values. It keeps reset low for several cycles before any operation or flag update is issued.

// File: rtl/fsx_pkg.sv
package fsx_pkg;
    localparam int DATA_W      = 32;
    localparam int EXP_W       = 8;
    localparam int MAN_W       = 23;
    localparam int FLAGS_W_DEF = 5;
    localparam int FLG_INVALID = 0;
    localparam int FLG_FLUSH   = 1;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUBNORM,
        CLS_NORMAL,
        CLS_INF,
        CLS_NAN
    } opclass_e;

    localparam logic [DATA_W-1:0] RES_ZERO = '0;
    localparam logic [DATA_W-1:0] RES_POS  = DATA_W'(1);
    localparam logic [DATA_W-1:0] RES_NEG  = '1;
endpackage

// File: rtl/fsx_classify.sv
module fsx_classify
    import fsx_pkg::*;
#(
    parameter int FLAG_W = FLAGS_W_DEF
) (
    input  logic [DATA_W-1:0] op,
    output logic [DATA_W-1:0] res,
    output logic [FLAG_W-1:0] flags
);
    localparam int EXP_LO = MAN_W;
    localparam int EXP_HI = MAN_W + EXP_W - 1;
    localparam int SGN    = DATA_W - 1;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    opclass_e         cls;

    always_comb begin
        exp_f = op[EXP_HI:EXP_LO];
        man_f = op[MAN_W-1:0];
        if (exp_f == '0) begin
            cls = (man_f == '0) ? CLS_ZERO : CLS_SUBNORM;
        end else if (exp_f == '1) begin
            cls = (man_f == '0) ? CLS_INF : CLS_NAN;
        end else begin
            cls = CLS_NORMAL;
        end
    end

    always_comb begin
        res   = RES_ZERO;
        flags = '0;
        unique case (cls)
            CLS_NORMAL, CLS_INF: res = op[SGN] ? RES_NEG : RES_POS;
            CLS_SUBNORM:         flags[FLG_FLUSH] = 1'b1;
            CLS_NAN:             flags[FLG_INVALID] = 1'b1;
            default:             res = RES_ZERO;
        endcase
    end
endmodule

// File: rtl/fsx_flag_merge.sv
module fsx_flag_merge #(
    parameter int FLAG_W  = 5,
    parameter int NUM_EXT = 2
) (
    input  logic [FLAG_W-1:0]         cur,
    input  logic                      wr_en,
    input  logic [FLAG_W-1:0]         wr_data,
    input  logic [FLAG_W-1:0]         own_upd,
    input  logic [NUM_EXT*FLAG_W-1:0] ext_upd,
    output logic [FLAG_W-1:0]         nxt
);
    logic [FLAG_W-1:0] acc [NUM_EXT+1];

    assign acc[0] = own_upd;

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_or
        assign acc[g+1] = acc[g] | ext_upd[g*FLAG_W +: FLAG_W];
    end

    assign nxt = (wr_en ? wr_data : cur) | acc[NUM_EXT];
endmodule

// File: rtl/fsx_sign_unit.sv
module fsx_sign_unit
    import fsx_pkg::*;
#(
    parameter int DEST_W  = 5,
    parameter int FLAG_W  = FLAGS_W_DEF,
    parameter int NUM_EXT = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      issue_valid,
    input  logic [DATA_W-1:0]         issue_operand,
    input  logic                      issue_guard,
    input  logic [DEST_W-1:0]         issue_dest,
    input  logic [NUM_EXT*FLAG_W-1:0] ext_flags,
    input  logic                      stat_wr_en,
    input  logic [FLAG_W-1:0]         stat_wr_data,
    output logic                      wb_valid,
    output logic [DEST_W-1:0]         wb_dest,
    output logic [DATA_W-1:0]         wb_data,
    output logic [FLAG_W-1:0]         stat_rd_data
);
    typedef struct packed {
        logic              vld;
        logic              grd;
        logic [DEST_W-1:0] dst;
        logic [DATA_W-1:0] opnd;
    } fetch_t;

    typedef struct packed {
        logic              vld;
        logic              grd;
        logic [DEST_W-1:0] dst;
        logic [DATA_W-1:0] res;
        logic [FLAG_W-1:0] fl;
    } eval_t;

    typedef struct packed {
        fetch_t            fe;
        eval_t             ev;
        logic              wb_v;
        logic [DEST_W-1:0] wb_dst;
        logic [DATA_W-1:0] wb_res;
        logic [FLAG_W-1:0] flags;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] cls_res;
    logic [FLAG_W-1:0] cls_flags;
    logic [FLAG_W-1:0] own_upd;
    logic [FLAG_W-1:0] flags_nxt;

    fsx_classify #(.FLAG_W(FLAG_W)) u_cls (
        .op    (st_q.fe.opnd),
        .res   (cls_res),
        .flags (cls_flags)
    );

    assign own_upd = (st_q.ev.vld && st_q.ev.grd) ? st_q.ev.fl : '0;

    fsx_flag_merge #(.FLAG_W(FLAG_W), .NUM_EXT(NUM_EXT)) u_merge (
        .cur     (st_q.flags),
        .wr_en   (stat_wr_en),
        .wr_data (stat_wr_data),
        .own_upd (own_upd),
        .ext_upd (ext_flags),
        .nxt     (flags_nxt)
    );

    always_comb begin
        st_d = st_q;
        // stage 1: capture
        st_d.fe.vld  = issue_valid;
        st_d.fe.grd  = issue_guard;
        st_d.fe.dst  = issue_dest;
        st_d.fe.opnd = issue_operand;
        // stage 2: classify
        st_d.ev.vld  = st_q.fe.vld;
        st_d.ev.grd  = st_q.fe.grd;
        st_d.ev.dst  = st_q.fe.dst;
        st_d.ev.res  = cls_res;
        st_d.ev.fl   = cls_flags;
        // stage 3: writeback and flag commit
        st_d.wb_v    = st_q.ev.vld && st_q.ev.grd;
        st_d.wb_dst  = st_q.ev.dst;
        st_d.wb_res  = st_q.ev.res;
        st_d.flags   = flags_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wb_valid     = st_q.wb_v;
    assign wb_dest      = st_q.wb_dst;
    assign wb_data      = st_q.wb_res;
    assign stat_rd_data = st_q.flags;
endmodule

// File: rtl/fsx_sign_checker.sv
module fsx_sign_checker
    import fsx_pkg::*;
#(
    parameter int DEST_W  = 5,
    parameter int FLAG_W  = FLAGS_W_DEF,
    parameter int NUM_EXT = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      issue_valid,
    input logic [DATA_W-1:0]         issue_operand,
    input logic                      issue_guard,
    input logic [DEST_W-1:0]         issue_dest,
    input logic [NUM_EXT*FLAG_W-1:0] ext_flags,
    input logic                      stat_wr_en,
    input logic [FLAG_W-1:0]         stat_wr_data,
    input logic                      wb_valid,
    input logic [DEST_W-1:0]         wb_dest,
    input logic [DATA_W-1:0]         wb_data,
    input logic [FLAG_W-1:0]         stat_rd_data
);
    logic [FLAG_W-1:0] ext_or;
    logic [2:0]        pv;
    logic [DEST_W-1:0] pd [3];

    always_comb begin
        ext_or = '0;
        for (int i = 0; i < NUM_EXT; i++) begin
            ext_or = ext_or | ext_flags[i*FLAG_W +: FLAG_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv    <= '0;
            pd[0] <= '0;
            pd[1] <= '0;
            pd[2] <= '0;
        end else begin
            pv    <= {pv[1:0], issue_valid & issue_guard};
            pd[0] <= issue_dest;
            pd[1] <= pd[0];
            pd[2] <= pd[1];
        end
    end

    AST_WB_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid == pv[2]); // R5
    AST_WB_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_dest == pd[2]); // R11
    AST_WB_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_data == RES_ZERO || wb_data == RES_POS || wb_data == RES_NEG)); // R2
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stat_wr_en) |-> (stat_rd_data & $past(stat_rd_data)) == $past(stat_rd_data)); // R7
    AST_EXT_MERGED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_data & $past(ext_or)) == $past(ext_or)); // R8
    AST_WRITE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stat_wr_en) |-> (stat_rd_data & $past(stat_wr_data)) == $past(stat_wr_data)); // R9
endmodule

bind fsx_sign_unit fsx_sign_checker #(
    .DEST_W(DEST_W), .FLAG_W(FLAG_W), .NUM_EXT(NUM_EXT)
) u_chk (.*);

// File: tb/fsx_sign_unit_test.sv
`timescale 1ns/1ps
module fsx_sign_unit_test;
    localparam int DW = 5;
    localparam int FW = 5;
    localparam int NE = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [31:0]   issue_operand = '0;
    logic          issue_guard = 1'b0;
    logic [DW-1:0] issue_dest = '0;
    logic [NE*FW-1:0] ext_flags = '0;
    logic          stat_wr_en = 1'b0;
    logic [FW-1:0] stat_wr_data = '0;
    logic          wb_valid;
    logic [DW-1:0] wb_dest;
    logic [31:0]   wb_data;
    logic [FW-1:0] stat_rd_data;

    always #10 clk = ~clk;

    fsx_sign_unit #(.DEST_W(DW), .FLAG_W(FW), .NUM_EXT(NE)) uut (.*);

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R10";
    bit    done = 1'b0;

    typedef struct {
        int            age;
        bit            g;
        logic [31:0]   r;
        logic [FW-1:0] f;
        logic [DW-1:0] d;
    } pend_t;
    pend_t pq[$];

    logic          m_wbv = 1'b0;
    logic [DW-1:0] m_wbd = '0;
    logic [31:0]   m_wbr = '0;
    logic [FW-1:0] m_flags = '0;

    function automatic void ref_eval(input logic [31:0] x, output logic [31:0] r,
                                     output logic [FW-1:0] f);
        f = '0;
        r = 32'd0;
        if (x[30:0] == 31'd0) begin
            r = 32'd0;
        end else if (x[30:23] == 8'd0) begin
            f[1] = 1'b1;
        end else if (x[30:23] == 8'hFF && x[22:0] != 23'd0) begin
            f[0] = 1'b1;
        end else begin
            r = x[31] ? 32'hFFFF_FFFF : 32'd1;
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pq.delete();
            m_flags = '0;
            m_wbv = 1'b0;
        end else begin
            logic [FW-1:0] nf;
            nf = stat_wr_en ? stat_wr_data : m_flags;
            for (int i = 0; i < NE; i++) nf = nf | ext_flags[i*FW +: FW];
            m_wbv = 1'b0;
            foreach (pq[i]) pq[i].age++;
            if (pq.size() > 0 && pq[0].age == 3) begin
                pend_t e;
                e = pq.pop_front();
                if (e.g) begin
                    m_wbv = 1'b1;
                    m_wbd = e.d;
                    m_wbr = e.r;
                    nf = nf | e.f;
                end
            end
            if (issue_valid) begin
                pend_t n;
                n.age = 1;
                n.g = issue_guard;
                n.d = issue_dest;
                ref_eval(issue_operand, n.r, n.f);
                pq.push_back(n);
            end
            m_flags = nf;
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check("wb_valid", 32'(wb_valid), 32'(m_wbv));
        if (m_wbv) begin
            check("wb_data", wb_data, m_wbr);
            check("wb_dest", 32'(wb_dest), 32'(m_wbd));
        end
        check("stat_rd_data", 32'(stat_rd_data), 32'(m_flags));
    endtask

    task automatic put(input logic [31:0] op, input logic g, input int d);
        issue_valid = 1'b1;
        issue_operand = op;
        issue_guard = g;
        issue_dest = DW'(d);
        tick();
        issue_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        issue_valid = 1'b0;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic clear_flags();
        stat_wr_en = 1'b1;
        stat_wr_data = '0;
        tick();
        stat_wr_en = 1'b0;
        idle(1);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        tag = "R10";
        check("reset stat", 32'(stat_rd_data), 32'd0);
        check("reset wb_valid", 32'(wb_valid), 32'd0);
        rst_n = 1'b1;
        tick();

        tag = "R1";
        put(32'h0000_0000, 1'b1, 1);
        put(32'h8000_0000, 1'b1, 2);
        idle(4);

        tag = "R2";
        put(32'h4040_0000, 1'b1, 3);
        put(32'hBF80_0000, 1'b1, 4);
        put(32'h8080_0000, 1'b1, 5);
        put(32'h7F80_0000, 1'b1, 6);
        put(32'hFF80_0000, 1'b1, 7);
        put(32'h3F80_0000, 1'b1, 8);
        idle(4);

        tag = "R3";
        put(32'h8040_0000, 1'b1, 9);
        put(32'h0000_0001, 1'b1, 10);
        put(32'h007F_FFFF, 1'b1, 11);
        idle(4);

        tag = "R4";
        clear_flags();
        put(32'hFFFF_FFFF, 1'b1, 12);
        put(32'h7F80_0001, 1'b1, 13);
        put(32'h7FC0_0000, 1'b1, 14);
        idle(4);

        tag = "R7";
        idle(8);

        tag = "R9";
        clear_flags();
        stat_wr_en = 1'b1;
        stat_wr_data = 5'b00100;
        ext_flags = {5'b10000, 5'b00000};
        tick();
        stat_wr_en = 1'b0;
        ext_flags = '0;
        idle(2);
        clear_flags();

        tag = "R6";
        put(32'hFFFF_FFFF, 1'b0, 15);
        put(32'h0000_0001, 1'b0, 16);
        put(32'hBF80_0000, 1'b0, 17);
        idle(5);
        check("stat after guarded-off ops", 32'(stat_rd_data), 32'd0);

        tag = "R8";
        ext_flags = {5'b00000, 5'b01000};
        tick();
        ext_flags = {5'b00100, 5'b00000};
        tick();
        ext_flags = '0;
        idle(3);
        clear_flags();

        tag = "R5";
        put(32'hC000_0000, 1'b1, 18);
        tick();
        tick();
        check("wb_valid third edge", 32'(wb_valid), 32'd1);
        idle(3);

        tag = "R11";
        for (int i = 0; i < 12; i++) begin
            logic [31:0] v;
            case (i % 6)
                0: v = 32'h4120_0000;
                1: v = 32'hC120_0000;
                2: v = 32'h0000_0000;
                3: v = 32'h0000_0F00;
                4: v = 32'h7FC0_0001;
                default: v = 32'hFF80_0000;
            endcase
            put(v, (i % 5) != 4, i + 19);
        end
        idle(5);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule